// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A behavioural, synthesizable model of a pipelined synchronous static RAM with a small internal array. By default the array is 64 words of 36 bits, and each word splits into four 9-bit byte lanes. Every control and address input is sampled on the rising clock edge. Read data leaves through an output register, so it appears one clock after the address is registered. An asynchronous active-low output enable gates that data. The pad tri-state is modelled as a data-valid flag.

Either of two address strobes opens an access. The processor strobe is the first. It only counts while the first chip select is active, and its accesses take their write data and write enables on the following cycle. The controller strobe is the second. It writes on the same edge it takes the address.

Between strobes, an advance input steps a two-bit wrapping burst counter. The access then continues as a read or a write at the new address. The counter follows either a linear order or an exclusive-or (interleaved) order, chosen by a static order input or fixed by a parameter.

Writes are byte-granular through a byte write enable and per-lane selects. A global write enable forces all lanes to be written. A strobe seen while the chip selects are not all active deselects the block and turns the outputs off.

Top module: `sync_burst_sram`

## Requirements
- R1: An access opens at a rising edge N when a qualified strobe is low. The processor strobe `pstb_ni` is qualified only while `sel1_ni` is low, and the controller strobe `cstb_ni` is always qualified. The access also needs all selects active (`sel1_ni`=0, `sel2_i`=1, `sel3_ni`=0). It is a read when `gwe_ni`=1 and `bwe_ni`=1, and when opened by the processor strobe it is always a read. The word at `adr_i` then drives `rdata_o` with `rdata_en_o`=1 after edge N+1, provided `oe_ni` is low.
- R2: While `sel1_ni` is high, a low `pstb_ni` is ignored. It neither opens an access nor deselects the block, so an ongoing read keeps its data and stays enabled.
- R3: Once read data is valid, `rdata_en_o` follows `oe_ni` combinationally, with no clock edge in between: it is low while `oe_ni` is high.
- R4: If an access opens at edge N while the block is deselected (or just out of reset), `rdata_en_o` stays low between edges N and N+1, whatever `oe_ni` is.
- R5: At an edge where a qualified strobe is low but the selects are not all active, the block becomes deselected and `rdata_en_o` is low right after that edge. It is also low during reset.
- R6: A controller-strobe access with `gwe_ni`=0 or `bwe_ni`=0 writes `wdata_i` to `adr_i` at the same edge.
- R7: A processor-strobe access ignores the write enables on its opening edge. On the next edge, with no strobe, `adv_ni`=1 and a write enable low, it writes `wdata_i` to the registered address.
- R8: With `bwe_ni`=0 and `gwe_ni`=1, lane i (bits 9i+8..9i) is written exactly when `bsel_ni[i]`=0, and the other lanes keep their contents.
- R9: With `gwe_ni`=0, all four lanes are written, whatever `bwe_ni` and `bsel_ni` are.
- R10: At an edge with no strobe, `adv_ni`=0 and the block selected, the two low address bits step to burst index k+1. With base b, index k is (b+k) mod 4 when `order_lin_i`=1 and b XOR k when it is 0. The upper address bits keep their value.
- R11: Reads opened on consecutive edges return a new word on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adr_i | input | 6 | Word address |
| pstb_ni | input | 1 | Processor address strobe, active low |
| cstb_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| sel1_ni | input | 1 | First chip select, active low |
| sel2_i | input | 1 | Second chip select, active high |
| sel3_ni | input | 1 | Third chip select, active low |
| gwe_ni | input | 1 | Global write enable, active low |
| bwe_ni | input | 1 | Byte write enable, active low |
| bsel_ni | input | 4 | Per-lane byte selects, active low |
| wdata_i | input | 36 | Write data |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| order_lin_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| rdata_o | output | 36 | Registered read data |
| rdata_en_o | output | 1 | Read data driven (models the output buffer being on) |

## Verification
The assertions take several things for granted. Reset must be held over at least one rising edge. The inputs must be settled around each edge. The order input must stay constant during a burst. The load and step requests reaching the burst counter are never raised together.

The stimulus changes every input only on the falling edge, and it keeps reset low for several cycles. It changes the order input only before a fresh processor-strobe access. It never writes a word on the edge right after a read of that same word has been registered, so the expected data in the bench's shadow array never depends on a read and a write colliding.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

   // Chooses how the burst order is set: by the order pin or fixed in hardware.
   typedef enum logic [1:0] {
      ORD_PIN = 2'd0,
      ORD_LIN = 2'd1,
      ORD_ILV = 2'd2
   } order_sel_e;

endpackage

// File: rtl/sbs_burst_ctr.sv
module sbs_burst_ctr
   import sbs_pkg::*;
#(
   parameter int         ADDR_W    = 6,
   parameter int         BURST_W   = 2,
   parameter order_sel_e ORDER_SEL = ORD_PIN
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic              step_i,
   input  logic              lin_i,
   input  logic [ADDR_W-1:0] adr_i,
   output logic [ADDR_W-1:0] cur_o,
   output logic [ADDR_W-1:0] nxt_o
);

   logic [ADDR_W-1:0]  base_q;
   logic [BURST_W-1:0] cnt_q;
   logic [BURST_W-1:0] cnt_nxt;
   logic               lin_eff;

   initial begin
      assert (BURST_W >= 1 && BURST_W < ADDR_W)
         else $error("burst width must be below address width");
   end

   generate
      if (ORDER_SEL == ORD_LIN) begin : g_fix_lin
         logic unused_lin;
         assign unused_lin = lin_i;
         assign lin_eff    = 1'b1;
      end else if (ORDER_SEL == ORD_ILV) begin : g_fix_ilv
         logic unused_lin;
         assign unused_lin = lin_i;
         assign lin_eff    = 1'b0;
      end else begin : g_pin
         assign lin_eff = lin_i;
      end
   endgenerate

   function automatic logic [BURST_W-1:0] seq_idx(input logic [BURST_W-1:0] b,
                                                  input logic [BURST_W-1:0] k,
                                                  input logic lin);
      return lin ? (b + k) : (b ^ k);
   endfunction

   assign cnt_nxt = cnt_q + BURST_W'(1);
   assign cur_o   = {base_q[ADDR_W-1:BURST_W], seq_idx(base_q[BURST_W-1:0], cnt_q, lin_eff)};
   assign nxt_o   = {base_q[ADDR_W-1:BURST_W], seq_idx(base_q[BURST_W-1:0], cnt_nxt, lin_eff)};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         base_q <= '0;
         cnt_q  <= '0;
      end else if (load_i) begin
         base_q <= adr_i;
         cnt_q  <= '0;
      end else if (step_i) begin
         cnt_q  <= cnt_nxt;
      end
   end

   AST_LOAD_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> cur_o == $past(adr_i)); // R10

   AST_STEP_KEEPS_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i && !load_i) |=> cur_o[ADDR_W-1:BURST_W] == $past(cur_o[ADDR_W-1:BURST_W])); // R10

endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
   parameter int ADDR_W = 6,
   parameter int LANE_W = 9,
   parameter int LANES  = 4
) (
   input  logic                      clk_i,
   input  logic                      wr_en_i,
   input  logic [LANES-1:0]          wr_mask_i,
   input  logic [ADDR_W-1:0]         wr_addr_i,
   input  logic [LANES*LANE_W-1:0]   wr_data_i,
   input  logic                      rd_en_i,
   input  logic [ADDR_W-1:0]         rd_addr_i,
   output logic [LANES*LANE_W-1:0]   rd_data_o
);

   localparam int DEPTH = 1 << ADDR_W;

   initial begin
      assert (DEPTH * LANES <= 4096) else $error("array too large for a model");
      assert (LANE_W >= 1 && LANES >= 1) else $error("bad lane geometry");
   end

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic [LANE_W-1:0] lane_mem [DEPTH];
         logic [LANE_W-1:0] rd_q;

         always_ff @(posedge clk_i) begin
            if (wr_en_i && wr_mask_i[l]) begin
               lane_mem[wr_addr_i] <= wr_data_i[l*LANE_W +: LANE_W];
            end
         end

         always_ff @(posedge clk_i) begin
            if (rd_en_i) begin
               rd_q <= lane_mem[rd_addr_i];
            end
         end

         assign rd_data_o[l*LANE_W +: LANE_W] = rd_q;
      end
   endgenerate

endmodule

// File: rtl/sbs_out_stage.sv
module sbs_out_stage (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic rd_pend_i,
   input  logic kill_i,
   input  logic oe_ni,
   output logic en_o
);

   logic valid_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_q <= 1'b0;
      end else if (kill_i) begin
         valid_q <= 1'b0;
      end else begin
         valid_q <= rd_pend_i;
      end
   end

   assign en_o = valid_q & ~oe_ni;

   AST_KILL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      kill_i |=> !en_o); // R5

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
   import sbs_pkg::*;
#(
   parameter int         ADDR_W    = 6,
   parameter int         LANE_W    = 9,
   parameter int         LANES     = 4,
   parameter int         BURST_W   = 2,
   parameter order_sel_e ORDER_SEL = ORD_PIN
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic [ADDR_W-1:0]       adr_i,
   input  logic                    pstb_ni,
   input  logic                    cstb_ni,
   input  logic                    adv_ni,
   input  logic                    sel1_ni,
   input  logic                    sel2_i,
   input  logic                    sel3_ni,
   input  logic                    gwe_ni,
   input  logic                    bwe_ni,
   input  logic [LANES-1:0]        bsel_ni,
   input  logic [LANES*LANE_W-1:0] wdata_i,
   input  logic                    oe_ni,
   input  logic                    order_lin_i,
   output logic [LANES*LANE_W-1:0] rdata_o,
   output logic                    rdata_en_o
);

   logic              sel_ok, p_hit, strobe;
   logic              start, desel, cont;
   logic              wr_req, wr_en, rd_next, step;
   logic [LANES-1:0]  wr_mask;
   logic [ADDR_W-1:0] cur_addr, nxt_addr, wr_addr;
   logic              act_q, rd_pend_q;

   // strobe qualification and access decode
   assign sel_ok  = !sel1_ni && sel2_i && !sel3_ni;
   assign p_hit   = !pstb_ni && !sel1_ni;
   assign strobe  = p_hit || !cstb_ni;
   assign start   = strobe && sel_ok;
   assign desel   = strobe && !sel_ok;
   assign cont    = !strobe && act_q;

   assign wr_req  = !gwe_ni || !bwe_ni;
   assign wr_mask = !gwe_ni ? {LANES{1'b1}} : (!bwe_ni ? ~bsel_ni : {LANES{1'b0}});

   assign wr_en   = (start && !p_hit && wr_req) || (cont && wr_req);
   assign rd_next = (start && (p_hit || !wr_req)) || (cont && !wr_req);
   assign step    = cont && !adv_ni;
   assign wr_addr = start ? adr_i : (step ? nxt_addr : cur_addr);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         act_q     <= 1'b0;
         rd_pend_q <= 1'b0;
      end else begin
         if (start) begin
            act_q <= 1'b1;
         end else if (desel) begin
            act_q <= 1'b0;
         end
         rd_pend_q <= rd_next;
      end
   end

   sbs_burst_ctr #(
      .ADDR_W    (ADDR_W),
      .BURST_W   (BURST_W),
      .ORDER_SEL (ORDER_SEL)
   ) ctr_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (start),
      .step_i (step),
      .lin_i  (order_lin_i),
      .adr_i  (adr_i),
      .cur_o  (cur_addr),
      .nxt_o  (nxt_addr)
   );

   sbs_array #(
      .ADDR_W (ADDR_W),
      .LANE_W (LANE_W),
      .LANES  (LANES)
   ) array_i (
      .clk_i     (clk_i),
      .wr_en_i   (wr_en),
      .wr_mask_i (wr_mask),
      .wr_addr_i (wr_addr),
      .wr_data_i (wdata_i),
      .rd_en_i   (rd_pend_q),
      .rd_addr_i (cur_addr),
      .rd_data_o (rdata_o)
   );

   sbs_out_stage out_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rd_pend_i (rd_pend_q),
      .kill_i    (desel),
      .oe_ni     (oe_ni),
      .en_o      (rdata_en_o)
   );

   AST_FIRST_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start && !act_q) |=> !rdata_en_o); // R4

   AST_PSTB_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel1_ni && cstb_ni) |=> act_q == $past(act_q)); // R2

   AST_DATA_HAS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rdata_en_o |-> $past(rd_pend_q)); // R1

endmodule

// File: tb/sync_burst_sram_tb_top.sv
module sync_burst_sram_tb_top;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [5:0]  adr;
   logic        pstb_n, cstb_n, adv_n;
   logic        sel1_n, sel2, sel3_n;
   logic        gwe_n, bwe_n;
   logic [3:0]  bsel_n;
   logic [35:0] wdata;
   logic        oe_n, lin;
   logic [35:0] rdata;
   logic        rden;

   int total = 0;
   int bad   = 0;
   logic [35:0] mem_m [64];

   always #(CLK_P/2) clk = ~clk;

   sync_burst_sram dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .adr_i       (adr),
      .pstb_ni     (pstb_n),
      .cstb_ni     (cstb_n),
      .adv_ni      (adv_n),
      .sel1_ni     (sel1_n),
      .sel2_i      (sel2),
      .sel3_ni     (sel3_n),
      .gwe_ni      (gwe_n),
      .bwe_ni      (bwe_n),
      .bsel_ni     (bsel_n),
      .wdata_i     (wdata),
      .oe_ni       (oe_n),
      .order_lin_i (lin),
      .rdata_o     (rdata),
      .rdata_en_o  (rden)
   );

   function automatic logic [35:0] pat(input int n);
      return 36'(n) * 36'h0_0F13_579 ^ 36'hA_5C30_F1E;
   endfunction

   task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic idle();
      pstb_n = 1'b1; cstb_n = 1'b1; adv_n = 1'b1;
      gwe_n = 1'b1; bwe_n = 1'b1; bsel_n = 4'hF;
   endtask

   task automatic sel_on();
      sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0;
   endtask

   task automatic model_wr(input int a, input logic [35:0] d, input logic gw,
                           input logic bw, input logic [3:0] bs);
      for (int l = 0; l < 4; l++) begin
         if (!gw || (!bw && !bs[l])) mem_m[a][l*9 +: 9] = d[l*9 +: 9];
      end
   endtask

   // controller-strobe access that writes at its own edge
   task automatic cwrite(input int a, input logic [35:0] d, input logic gw,
                         input logic bw, input logic [3:0] bs);
      idle(); sel_on();
      cstb_n = 1'b0; adr = 6'(a); wdata = d;
      gwe_n = gw; bwe_n = bw; bsel_n = bs;
      tick();
      model_wr(a, d, gw, bw, bs);
   endtask

   // back-to-back controller-strobe reads; data of edge i is checked after edge i+1
   task automatic rd_sweep(input int lo, input int hi, input string req);
      for (int i = lo; i <= hi + 1; i++) begin
         idle(); sel_on();
         if (i <= hi) begin
            cstb_n = 1'b0; adr = 6'(i);
         end
         tick();
         if (i > lo) begin
            chk({req, " en"}, 36'(rden), 36'd1);
            chk({req, " data"}, rdata, mem_m[i-1]);
         end
      end
   endtask

   initial begin
      #(CLK_P * 200000);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int a0, off, ex;
      rst_n = 1'b0; oe_n = 1'b0; lin = 1'b1;
      adr = '0; wdata = '0;
      idle(); sel_on();
      for (int i = 0; i < 64; i++) mem_m[i] = '0;
      repeat (4) tick();
      chk("R5 reset off", 36'(rden), 36'd0);
      rst_n = 1'b1;
      tick();

      // fill every word with global write (R6, R9)
      for (int a = 0; a < 64; a++) cwrite(a, pat(a), 1'b0, 1'b1, 4'hF);
      // full read sweep, one word per cycle (R1, R11)
      rd_sweep(0, 63, "R11");

      // asynchronous output enable (R3)
      oe_n = 1'b1; #1;
      chk("R3 oe high", 36'(rden), 36'd0);
      oe_n = 1'b0; #1;
      chk("R3 oe low", 36'(rden), 36'd1);
      chk("R3 data held", rdata, mem_m[63]);

      // deselect by controller strobe with second select inactive (R5)
      idle(); cstb_n = 1'b0; sel2 = 1'b0;
      tick();
      chk("R5 deselect off", 36'(rden), 36'd0);
      idle(); sel_on(); tick();
      chk("R5 stays off", 36'(rden), 36'd0);

      // access opened from deselected: first cycle off (R4), then data (R1)
      idle(); sel_on(); pstb_n = 1'b0; adr = 6'd5;
      tick();
      chk("R4 first cycle off", 36'(rden), 36'd0);
      idle(); tick();
      chk("R1 en", 36'(rden), 36'd1);
      chk("R1 data", rdata, mem_m[5]);

      // processor strobe while first select high is ignored (R2)
      idle(); sel1_n = 1'b1; sel2 = 1'b0; pstb_n = 1'b0; adr = 6'd9;
      tick(); tick();
      chk("R2 en kept", 36'(rden), 36'd1);
      chk("R2 data kept", rdata, mem_m[5]);
      sel_on();

      // byte writes over every lane mask (R8)
      for (int m = 0; m < 16; m++) cwrite(16 + m, pat(100 + m), 1'b1, 1'b0, ~4'(m));
      // global write overrides lane selects (R9)
      cwrite(40, pat(200), 1'b0, 1'b1, 4'hF);
      cwrite(41, pat(201), 1'b0, 1'b0, 4'h5);
      rd_sweep(16, 31, "R8");
      rd_sweep(40, 41, "R9");

      // processor strobe ignores write enables on its opening edge (R7)
      idle(); sel_on(); pstb_n = 1'b0; adr = 6'd60; gwe_n = 1'b0; wdata = 36'hF_FFFF_FFFF;
      tick();
      idle(); tick();
      chk("R7 open edge no write", rdata, mem_m[60]);

      // processor-strobe write, then an advanced write (R7, R10)
      idle(); sel_on(); pstb_n = 1'b0; adr = 6'd50;
      tick();
      idle(); gwe_n = 1'b0; wdata = pat(300);
      tick();
      model_wr(50, pat(300), 1'b0, 1'b1, 4'hF);
      idle(); adv_n = 1'b0; gwe_n = 1'b0; wdata = pat(301);
      tick();
      model_wr(51, pat(301), 1'b0, 1'b1, 4'hF);
      rd_sweep(50, 51, "R7");

      // bursts from every start offset in both orders (R10)
      for (int ord = 0; ord < 2; ord++) begin
         for (int o = 0; o < 4; o++) begin
            off = o; a0 = 32 + o;
            lin = ord[0];
            idle(); sel_on(); pstb_n = 1'b0; adr = 6'(a0);
            tick();
            for (int k = 1; k <= 4; k++) begin
               idle();
               if (k <= 3) adv_n = 1'b0;
               tick();
               ex = (a0 & ~3) | (ord == 1 ? ((off + k - 1) & 3) : (off ^ (k - 1)));
               chk("R10 burst data", rdata, mem_m[ex]);
            end
         end
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule